// File: doc/BRIEF.md
# Minimal 32-bit RISC Execution Core

This block is a small 32-bit processor core. It reads fixed 32-bit instruction words from a word-addressed instruction memory that has one cycle of read latency, and it runs a compact instruction subset: immediate loads into either half of a register, register add, equality compare, full byte-order reversal, PC-relative branches (one unconditional, one taken on "not equal"), no-operation and halt. The core holds sixteen 32-bit registers, with r0 fixed at zero, and a single compare flag.

Every instruction takes two cycles. In the fetch cycle the core presents the program counter on the address port. In the execute cycle it decodes the word that the memory returns. Out of reset the core always starts with a fetch cycle, so it never decodes a stale or cleared word that sits on the data port. A halt freezes the program counter and raises `halted` until the next reset. A debug output shows the value computed by the most recent register-writing instruction.

Top module: `lean32_core`

## Requirements
- R1: While reset is high and on the first cycle after it, `halted` is 0, `imem_addr` is 0 and `alu_dbg` is 0. Reset also clears all registers and the not-equal flag.
- R2: Fetch and execute cycles alternate. A word is decoded only in the cycle after its address was presented. Whatever is on `imem_data` during the first cycle after reset is never executed.
- R3: The opcode sits in bits 31:24, the destination register in bits 23:20, the first source register in bits 19:16, the second source register in bits 15:12 and the immediate in bits 15:0. Opcode 0x41 writes the immediate into bits 31:16 of the destination register. Opcode 0x40 writes it into bits 15:0. Each of these loads keeps the other half of the register.
- R4: Opcode 0x20 writes the sum of the first and second source registers to the destination register. Register r0 reads as zero, so adding r0 copies a register.
- R5: Opcode 0x38 writes the byte-reversed value of the second source register to the destination register (0x12345678 becomes 0x78563412).
- R6: Opcode 0x22 sets the not-equal flag when the two source registers differ and clears it when they are equal. Opcode 0xC8 branches only while the flag is set. No other opcode changes the flag.
- R7: Opcode 0xC0 always branches. For both branches the target is the address of the branch plus the signed offset in bits 23:0, taken modulo the instruction address space. Forward and backward offsets both work.
- R8: An instruction that does not branch or halt advances the program counter by one word.
- R9: Opcode 0x01 halts. `halted` goes to 1, `imem_addr` stays at the address of the halt instruction, and both hold until reset.
- R10: Opcode 0x00, and any opcode not listed here, changes no register and no flag. It only advances the program counter.
- R11: A write to r0 has no effect, and r0 still reads as zero afterwards.
- R12: `alu_dbg` holds the value computed by the most recent add, byte swap or immediate load, including one aimed at r0. Compare, branch, no-operation and undefined opcodes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | IMEM_AW | Word address of the instruction to fetch |
| imem_data | input | 32 | Instruction word, valid one cycle after its address |
| halted | output | 1 | High once a halt instruction has executed |
| alu_dbg | output | 32 | Result of the last register-writing instruction |

## Verification
A wrong program counter shows up within two cycles as a wrong value on `imem_addr`. The bench does not watch it cycle by cycle. It checks the address at which the core finally halts, and each program places separate halt words on the pass path and on the fail path. A bad register value or a wrong flag stays hidden until a later add, swap or branch uses it. For that reason each program ends by routing its data through a writing instruction, so the value reaches `alu_dbg`, and it uses a conditional branch to turn the state of the flag into a halt address. If the core decoded the stale word on the data port out of reset, it would halt at address 0 within two cycles, because the bench puts a halt word on the data port while reset is high.

// File: rtl/lean32_pkg.sv
package lean32_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 16;
    localparam int RIDX_W = $clog2(NREGS);

    // Opcode byte values (bits 31:24 of an instruction)
    localparam logic [7:0] OPC_NOP  = 8'h00;
    localparam logic [7:0] OPC_HALT = 8'h01;
    localparam logic [7:0] OPC_ADD  = 8'h20;
    localparam logic [7:0] OPC_CMP  = 8'h22;
    localparam logic [7:0] OPC_SWAP = 8'h38;
    localparam logic [7:0] OPC_LDLO = 8'h40;
    localparam logic [7:0] OPC_LDHI = 8'h41;
    localparam logic [7:0] OPC_JMP  = 8'hC0;
    localparam logic [7:0] OPC_JNE  = 8'hC8;

    typedef enum logic [3:0] {
        K_NONE, K_HALT, K_ADD, K_CMP, K_SWAP, K_LDLO, K_LDHI, K_JMP, K_JNE
    } kind_e;

    typedef enum logic {PH_FETCH, PH_EXEC} phase_e;

    typedef struct packed {
        kind_e                kind;
        logic [RIDX_W-1:0]    rd;
        logic [RIDX_W-1:0]    rs1;
        logic [RIDX_W-1:0]    rs2;
        logic [15:0]          imm16;
        logic                 wr_en;
    } dec_t;

    function automatic logic [XLEN-1:0] byte_rev(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN/8; i++)
            r[8*i +: 8] = v[XLEN-8-8*i +: 8];
        return r;
    endfunction

endpackage

// File: rtl/lean32_decode.sv
module lean32_decode
    import lean32_pkg::*;
#(
    parameter int PCW = 10
) (
    input  logic [31:0]    insn,
    output dec_t           dec,
    output logic [PCW-1:0] boff
);
    kind_e k;

    always_comb begin
        case (insn[31:24])
            OPC_HALT: k = K_HALT;
            OPC_ADD:  k = K_ADD;
            OPC_CMP:  k = K_CMP;
            OPC_SWAP: k = K_SWAP;
            OPC_LDLO: k = K_LDLO;
            OPC_LDHI: k = K_LDHI;
            OPC_JMP:  k = K_JMP;
            OPC_JNE:  k = K_JNE;
            default:  k = K_NONE;   // covers OPC_NOP and undefined codes
        endcase
    end

    always_comb begin
        dec.kind  = k;
        dec.rd    = insn[23:20];
        dec.rs1   = insn[19:16];
        dec.rs2   = insn[15:12];
        dec.imm16 = insn[15:0];
        dec.wr_en = (k == K_ADD) || (k == K_SWAP) || (k == K_LDLO) || (k == K_LDHI);
    end

    // Low bits of the signed offset; truncation gives modulo wrap of the PC
    assign boff = insn[PCW-1:0];

endmodule

// File: rtl/lean32_regfile.sv
module lean32_regfile #(
    parameter int NREG = 16,
    parameter int W    = 32,
    parameter int NRD  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NREG)-1:0] raddr [NRD],
    output logic [W-1:0]            rdata [NRD],
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [W-1:0]            wdata
);
    localparam int IW = $clog2(NREG);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && waddr != IW'(0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = regs[raddr[g]];
    end

    // R11
    r0_zero_chk: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0);

endmodule

// File: rtl/lean32_alu.sv
module lean32_alu
    import lean32_pkg::*;
(
    input  kind_e             kind,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    input  logic [XLEN-1:0]   rd_old,
    input  logic [15:0]       imm16,
    output logic [XLEN-1:0]   result,
    output logic              differ
);
    always_comb begin
        case (kind)
            K_ADD:   result = a + b;
            K_SWAP:  result = byte_rev(b);
            K_LDLO:  result = {rd_old[XLEN-1:16], imm16};
            K_LDHI:  result = {imm16, rd_old[15:0]};
            default: result = '0;
        endcase
    end

    assign differ = (a != b);

endmodule

// File: rtl/lean32_core.sv
module lean32_core
    import lean32_pkg::*;
#(
    parameter int IMEM_AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    output logic [IMEM_AW-1:0] imem_addr,
    input  logic [31:0]        imem_data,
    output logic               halted,
    output logic [31:0]        alu_dbg
);
    localparam logic [IMEM_AW-1:0] PC_ONE = IMEM_AW'(1);

    phase_e              phase_q;
    logic [IMEM_AW-1:0]  pc_q;
    logic                halted_q;
    logic                ne_q;
    logic [XLEN-1:0]     dbg_q;

    dec_t                dec;
    logic [IMEM_AW-1:0]  boff;
    logic [RIDX_W-1:0]   rf_ra [3];
    logic [XLEN-1:0]     rf_rd [3];
    logic [XLEN-1:0]     alu_res;
    logic                alu_ne;
    logic                exec;
    logic                take;

    lean32_decode #(.PCW(IMEM_AW)) u_dec (
        .insn (imem_data),
        .dec  (dec),
        .boff (boff)
    );

    assign rf_ra[0] = dec.rs1;
    assign rf_ra[1] = dec.rs2;
    assign rf_ra[2] = dec.rd;

    assign exec = (phase_q == PH_EXEC) && !halted_q;

    lean32_regfile #(.NREG(NREGS), .W(XLEN), .NRD(3)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .raddr (rf_ra),
        .rdata (rf_rd),
        .we    (exec && dec.wr_en),
        .waddr (dec.rd),
        .wdata (alu_res)
    );

    lean32_alu u_alu (
        .kind   (dec.kind),
        .a      (rf_rd[0]),
        .b      (rf_rd[1]),
        .rd_old (rf_rd[2]),
        .imm16  (dec.imm16),
        .result (alu_res),
        .differ (alu_ne)
    );

    assign take = (dec.kind == K_JMP) || (dec.kind == K_JNE && ne_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_FETCH;
            pc_q     <= '0;
            halted_q <= 1'b0;
            ne_q     <= 1'b0;
            dbg_q    <= '0;
        end else if (!halted_q) begin
            if (phase_q == PH_FETCH) begin
                phase_q <= PH_EXEC;
            end else begin
                phase_q <= PH_FETCH;
                if (dec.kind == K_HALT)
                    halted_q <= 1'b1;
                else if (take)
                    pc_q <= pc_q + boff;
                else
                    pc_q <= pc_q + PC_ONE;
                if (dec.kind == K_CMP)
                    ne_q <= alu_ne;
                if (dec.wr_en)
                    dbg_q <= alu_res;
            end
        end
    end

    assign imem_addr = pc_q;
    assign halted    = halted_q;
    assign alu_dbg   = dbg_q;

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> (halted_q && $stable(pc_q)));

    // R2
    exec_alternate_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC) |=> (phase_q == PH_FETCH));

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (exec && !take && dec.kind != K_HALT) |=> (pc_q == $past(pc_q) + PC_ONE));

    // R6
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (exec && dec.kind != K_CMP) |=> $stable(ne_q));

    // R12
    dbg_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!exec || !dec.wr_en) |=> $stable(dbg_q));

endmodule

// File: tb/lean32_core_test.sv
`timescale 1ns/1ps
module lean32_core_test;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam logic [31:0] HCF = 32'h0100_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] imem_addr;
    logic [31:0]   imem_q;
    logic          halted;
    logic [31:0]   alu_dbg;

    logic [31:0]   mem [DEPTH];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lean32_core #(.IMEM_AW(AW)) uut (
        .clk       (clk),
        .rst       (rst),
        .imem_addr (imem_addr),
        .imem_data (imem_q),
        .halted    (halted),
        .alu_dbg   (alu_dbg)
    );

    // Instruction memory with one-cycle read; a halt word sits on the bus during reset
    always @(posedge clk) begin
        if (rst) imem_q <= HCF;
        else     imem_q <= mem[imem_addr];
    end

    function automatic logic [31:0] enc_r(logic [7:0] op, logic [3:0] rd, logic [3:0] s1, logic [3:0] s2);
        return {op, rd, s1, s2, 12'h000};
    endfunction
    function automatic logic [31:0] enc_i(logic [7:0] op, logic [3:0] rd, logic [15:0] imm);
        return {op, rd, 4'h0, imm};
    endfunction
    function automatic logic [31:0] enc_b(logic [7:0] op, int off);
        logic [31:0] o = off;
        return {op, o[23:0]};
    endfunction
    function automatic logic [31:0] ref_swap(logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) mem[i] = HCF;
    endtask

    // Reset, check reset state, release, wait for halt, check final state
    task automatic run(string req, int exp_addr, logic [31:0] exp_dbg);
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset halted", 32'(halted), 32'd0);
        check("R1 reset addr", 32'(imem_addr), 32'd0);
        check("R1 reset dbg", alu_dbg, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 no stale decode", 32'(halted), 32'd0);
        for (int i = 0; i < 600 && !halted; i++) @(negedge clk);
        check({req, " halted"}, 32'(halted), 32'd1);
        check({req, " halt addr"}, 32'(imem_addr), 32'(exp_addr));
        check({req, " dbg"}, alu_dbg, exp_dbg);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);

        // Byte-swap program, matching path: R3 R5 R6 R4 R2
        clear_mem();
        mem[0] = enc_i(8'h41, 4'd8, 16'h1234);
        mem[1] = enc_i(8'h40, 4'd8, 16'h5678);
        mem[2] = enc_r(8'h38, 4'd8, 4'd0, 4'd8);
        mem[3] = enc_i(8'h41, 4'd9, 16'h7856);
        mem[4] = enc_i(8'h40, 4'd9, 16'h3412);
        mem[5] = enc_r(8'h22, 4'd0, 4'd8, 4'd9);
        mem[6] = enc_b(8'hC8, 3);
        mem[7] = enc_r(8'h20, 4'd12, 4'd8, 4'd0);
        mem[8] = HCF;
        mem[9] = HCF;
        run("R5 swap match", 8, 32'h7856_3412);

        // R9: frozen after halt
        repeat (20) @(negedge clk);
        check("R9 halt held", 32'(halted), 32'd1);
        check("R9 addr frozen", 32'(imem_addr), 32'd8);

        // Mismatch reaches the failure halt (R6), lower-half load keeps upper (R3)
        mem[4] = enc_i(8'h40, 4'd9, 16'h3413);
        run("R6 mismatch halt", 9, 32'h7856_3413);

        // R1 R6: flag cleared by reset, so JNE falls through
        clear_mem();
        mem[0] = enc_b(8'hC8, 2);
        run("R6 flag reset", 1, 32'd0);

        // R7: forward and backward JMP, R4 add
        clear_mem();
        mem[0] = enc_b(8'hC0, 3);
        mem[3] = enc_i(8'h40, 4'd2, 16'd7);
        mem[4] = enc_b(8'hC0, -3);
        mem[1] = enc_r(8'h20, 4'd3, 4'd2, 4'd2);
        run("R7 branch", 2, 32'd14);

        // R11: write to r0 ignored; R12 dbg shows the attempted value first
        clear_mem();
        mem[0] = enc_i(8'h41, 4'd0, 16'hFFFF);
        mem[1] = enc_r(8'h20, 4'd1, 4'd0, 4'd0);
        run("R11 r0 zero", 2, 32'd0);

        // R10 R12: NOP and undefined opcode change nothing
        clear_mem();
        mem[0] = 32'h0000_0000;
        mem[1] = enc_i(8'h40, 4'd1, 16'd9);
        mem[2] = 32'h7712_3456;
        mem[3] = enc_r(8'h20, 4'd2, 4'd1, 4'd0);
        mem[4] = enc_r(8'h22, 4'd0, 4'd1, 4'd1);
        run("R10 undefined op", 5, 32'd9);

        // Random add/swap/compare programs (R3 R4 R5 R6 R8)
        for (int it = 0; it < 40; it++) begin
            logic [31:0] a, b;
            a = $urandom();
            b = ($urandom() % 4 == 0) ? a : $urandom();
            if (it == 0) b = a;
            clear_mem();
            mem[0] = enc_i(8'h41, 4'd1, a[31:16]);
            mem[1] = enc_i(8'h40, 4'd1, a[15:0]);
            mem[2] = enc_i(8'h41, 4'd2, b[31:16]);
            mem[3] = enc_i(8'h40, 4'd2, b[15:0]);
            mem[4] = enc_r(8'h20, 4'd3, 4'd1, 4'd2);
            mem[5] = enc_r(8'h38, 4'd4, 4'd0, 4'd3);
            mem[6] = enc_r(8'h22, 4'd0, 4'd1, 4'd2);
            mem[7] = enc_b(8'hC8, 2);
            run("R4 random", (a != b) ? 9 : 8, ref_swap(a + b));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule